// File: doc/BRIEF.md
# Pulse Accumulator with Gated Timing

This block is the pulse-accumulation part of a general-purpose timer. A single external input is brought into the clock domain through a synchronizer. A 16-bit counter then advances in one of two ways. In edge mode it counts one chosen edge of that input. In gated mode it counts a divide-by-64 tick from the timer prescaler, but only while the input holds a chosen level. The edge that closes the gate raises a flag.

Software reaches a control register, a status register and the counter through a small word-wide register port. Status flags are cleared by writing ones to them. An interrupt request combines each flag with its own enable.

The block also picks the clock-enable pulse for the main timer counter. That pulse is either the prescaler pulse or one of three clocks derived from the accumulator: one pulse per increment, one per low-byte rollover, or one per full wrap.

Top module: `pacc_top`

## Requirements
- R1: After a synchronous reset, the control register, status flags and counter all read 0, and `irq` is low.
- R2: The control register (address 0) has this layout: bit 6 enable, bit 5 gated mode, bit 4 polarity, bits 3:2 timer clock select, bit 1 overflow interrupt enable, bit 0 edge interrupt enable. Bit 7 and all higher bits read 0, whatever was written to them.
- R3: While the enable bit is 0, the counter holds its value.
- R4: In edge mode (bit 5 = 0), each synchronized rising edge advances the counter by one when polarity = 1. Each falling edge advances it when polarity = 0.
- R5: In gated mode (bit 5 = 1), each `div64_tick` advances the counter while the synchronized input is high (polarity = 0) or low (polarity = 1). At the other level the tick is not counted.
- R6: Gated counting needs `tmr_en` = 1. Edge counting goes on while `tmr_en` = 0.
- R7: While enabled, the edge flag (status bit 0) is set by a rising edge when polarity = 1 and by a falling edge when polarity = 0. In gated mode this is the edge that ends the gate. The opposite edge does not set it.
- R8: An increment that takes the counter from 0xFFFF to 0 sets the overflow flag (status bit 1).
- R9: Writing 1 to a status bit at address 1 clears that bit. If the flag's set condition occurs in the same cycle, the set wins.
- R10: `irq` is high exactly when (edge flag AND control bit 0) OR (overflow flag AND control bit 1).
- R11: `tmr_clk_en` follows `presc_tick` when the select is 00 or when enable = 0. Select 01 gives one pulse per increment. Select 10 gives one pulse per increment out of a low byte of 0xFF. Select 11 gives one pulse per wrap. Derived pulses appear in the cycle after the increment. A new select takes effect in the cycle after the write.
- R12: The counter (address 2) can be written and read. A write wins over an increment in the same cycle. Read data appears in the cycle after the address is presented. An input change is counted on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status, 2 counter) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| acc_pin | input | 1 | Asynchronous accumulator input |
| presc_tick | input | 1 | Prescaler clock-enable pulse |
| div64_tick | input | 1 | Divide-by-64 prescaler pulse |
| tmr_en | input | 1 | Timer enable |
| tmr_clk_en | output | 1 | Selected clock enable for the main timer counter |
| flag_edge | output | 1 | Edge flag |
| flag_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle: a hardware flag set against a software write-one-to-clear, and a counted edge against a software write to the counter. The bench knows that an input change is counted on the third rising edge after it. It uses that to time a status clear so that it lands in exactly the cycle where 0xFFFF wraps to 0, and in a second run it lands a counter write on an increment cycle. It then judges the outcome by reading back: both flags must still be set, and the counter must hold the written value with no increment added.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int CTRL_W   = 8;
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CNT  = 2;

  typedef enum logic [1:0] {
    TCLK_PRESC  = 2'b00,
    TCLK_STEP   = 2'b01,
    TCLK_LOWROL = 2'b10,
    TCLK_WRAP   = 2'b11
  } tclk_sel_e;

  typedef struct packed {
    logic      rsvd;
    logic      en;
    logic      gated;
    logic      pol;
    tclk_sel_e clk_sel;
    logic      ovf_ie;
    logic      edge_ie;
  } ctrl_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], pin};
  end

  assign level = chain_q[SYNC_STAGES-1];
  assign rise  =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall  = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             gated,
  input  logic             pol,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  input  logic             div_tick,
  input  logic             tmr_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             edge_hit,
  output logic             wrap,
  output logic             p_step_q,
  output logic             p_low_q,
  output logic             p_wrap_q
);
  logic             edge_sel;
  logic             gate_open;
  logic             inc_raw;
  logic             inc_eff;
  logic             low_roll;
  logic [CNT_W-1:0] cnt_q;

  assign edge_sel  = pol ? rise : fall;
  assign gate_open = pol ? ~level : level;
  assign inc_raw   = en & (gated ? (gate_open & div_tick & tmr_en) : edge_sel);
  assign inc_eff   = inc_raw & ~load;
  assign low_roll  = inc_eff & (&cnt_q[LOW_W-1:0]);
  assign wrap      = inc_eff & (&cnt_q);
  assign edge_hit  = en & edge_sel;
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (inc_eff) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_step_q <= 1'b0;
      p_low_q  <= 1'b0;
      p_wrap_q <= 1'b0;
    end else begin
      p_step_q <= inc_eff;
      p_low_q  <= low_roll;
      p_wrap_q <= wrap;
    end
  end
endmodule

// File: rtl/pacc_clk_mux.sv
module pacc_clk_mux
  import pacc_pkg::*;
(
  input  logic      en,
  input  tclk_sel_e sel,
  input  logic      presc_tick,
  input  logic      p_step,
  input  logic      p_low,
  input  logic      p_wrap,
  output logic      clk_en
);
  always_comb begin
    clk_en = presc_tick;
    if (en) begin
      case (sel)
        TCLK_PRESC:  clk_en = presc_tick;
        TCLK_STEP:   clk_en = p_step;
        TCLK_LOWROL: clk_en = p_low;
        TCLK_WRAP:   clk_en = p_wrap;
      endcase
    end
  end
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_pin,
  input  logic              presc_tick,
  input  logic              div64_tick,
  input  logic              tmr_en,
  output logic              tmr_clk_en,
  output logic              flag_edge,
  output logic              flag_ovf,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);

  ctrl_t             ctrl_q;
  logic              ctrl_en_w;
  logic              ctrl_gated_w;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_w;
  logic              lvl_w, rise_w, fall_w;
  logic              edge_hit_w, wrap_w;
  logic              p_step_w, p_low_w, p_wrap_w;
  logic              edge_q, ovf_q;
  logic              edge_clr, ovf_clr;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_en_w    = ctrl_q.en;
  assign ctrl_gated_w = ctrl_q.gated;
  assign cnt_load     = reg_wr && (reg_addr == A_CNT);
  assign edge_clr     = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
  assign ovf_clr      = reg_wr && (reg_addr == A_STAT) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst)                               ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'({1'b0, reg_wdata[CTRL_W-2:0]});
  end

  pacc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(acc_pin),
    .level(lvl_w), .rise(rise_w), .fall(fall_w)
  );

  pacc_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst(rst),
    .en(ctrl_en_w), .gated(ctrl_gated_w), .pol(ctrl_q.pol),
    .level(lvl_w), .rise(rise_w), .fall(fall_w),
    .div_tick(div64_tick), .tmr_en(tmr_en),
    .load(cnt_load), .load_val(reg_wdata[CNT_W-1:0]),
    .cnt(cnt_w), .edge_hit(edge_hit_w), .wrap(wrap_w),
    .p_step_q(p_step_w), .p_low_q(p_low_w), .p_wrap_q(p_wrap_w)
  );

  pacc_clk_mux u_mux (
    .en(ctrl_en_w), .sel(ctrl_q.clk_sel), .presc_tick(presc_tick),
    .p_step(p_step_w), .p_low(p_low_w), .p_wrap(p_wrap_w),
    .clk_en(tmr_clk_en)
  );

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      edge_q <= edge_hit_w | (edge_q & ~edge_clr);
      ovf_q  <= wrap_w     | (ovf_q  & ~ovf_clr);
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_CTRL:  rd_next[CTRL_W-1:0] = ctrl_q;
      A_STAT:  rd_next[1:0]        = {ovf_q, edge_q};
      A_CNT:   rd_next[CNT_W-1:0]  = cnt_w;
      default: rd_next             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign flag_edge = edge_q;
  assign flag_ovf  = ovf_q;
  assign irq       = (edge_q & ctrl_q.edge_ie) | (ovf_q & ctrl_q.ovf_ie);
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              tmr_en,
  input logic              ctrl_en,
  input logic              ctrl_gated,
  input logic              load,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag_edge,
  input logic              flag_ovf,
  input logic              irq
);
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !load) |=> $stable(cnt));

  a_r6_gated_needs_timer: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && ctrl_gated && !tmr_en && !load) |=> $stable(cnt));

  a_r8_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    ((cnt == {CNT_W{1'b1}}) && !load) ##1 (cnt == '0) |-> flag_ovf);

  a_r10_no_flag_no_irq: assert property (@(posedge clk) disable iff (rst)
    (!flag_edge && !flag_ovf) |-> !irq);

  a_r2_upper_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && $past(reg_addr) == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:7] == '0));
endmodule

bind pacc_top pacc_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .tmr_en(tmr_en), .ctrl_en(ctrl_en_w), .ctrl_gated(ctrl_gated_w), .load(cnt_load),
  .cnt(cnt_w), .flag_edge(flag_edge), .flag_ovf(flag_ovf), .irq(irq)
);

// File: tb/pacc_top_tb_top.sv
module pacc_top_tb_top;
  import pacc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;
  localparam logic [1:0] A_CTRL = 2'(REG_CTRL);
  localparam logic [1:0] A_STAT = 2'(REG_STAT);
  localparam logic [1:0] A_CNT  = 2'(REG_CNT);

  typedef struct packed {
    logic [6:0]  ctrl;
    logic [3:0]  npulse;
    logic [3:0]  ntick;
    logic        lvl;
    logic        ten;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{7'h50, 4'd3, 4'd0, 1'b0, 1'b1, 16'd3}, // R4 rising edges
    '{7'h40, 4'd3, 4'd0, 1'b1, 1'b1, 16'd3}, // R4 falling edges
    '{7'h50, 4'd2, 4'd0, 1'b0, 1'b0, 16'd2}, // R6 edge mode, timer off
    '{7'h00, 4'd3, 4'd0, 1'b0, 1'b1, 16'd0}, // R3 disabled
    '{7'h60, 4'd0, 4'd5, 1'b1, 1'b1, 16'd5}, // R5 high level open
    '{7'h60, 4'd0, 4'd5, 1'b0, 1'b1, 16'd0}, // R5 low level closed
    '{7'h70, 4'd0, 4'd4, 1'b0, 1'b1, 16'd4}, // R5 low level open
    '{7'h70, 4'd0, 4'd4, 1'b1, 1'b1, 16'd0}, // R5 high level closed
    '{7'h60, 4'd0, 4'd5, 1'b1, 1'b0, 16'd0}, // R6 gated, timer off
    '{7'h20, 4'd0, 4'd5, 1'b1, 1'b1, 16'd0}  // R3 gated but disabled
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_pin = 1'b0;
  logic        presc_tick = 1'b0;
  logic        div64_tick = 1'b0;
  logic        tmr_en = 1'b1;
  logic        tmr_clk_en, flag_edge, flag_ovf, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  int mon_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pacc_top dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_pin(acc_pin),
    .presc_tick(presc_tick), .div64_tick(div64_tick), .tmr_en(tmr_en),
    .tmr_clk_en(tmr_clk_en), .flag_edge(flag_edge), .flag_ovf(flag_ovf), .irq(irq)
  );

  always begin
    @(negedge clk);
    #1;
    if (mon_on && tmr_clk_en) mon_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pin_set(input logic v);
    acc_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    div64_tick = 1'b1;
    @(negedge clk);
    div64_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all actual=timeout expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_CNT, v);  chk("R1 counter", v, 0);
    chk("R1 irq", irq, 0);

    // R2 reserved bit
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, v); chk("R2 ctrl readback", v, 16'h007F);
    wr(A_CTRL, 16'h0000);

    // R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 0);
      tmr_en = VEC[i].ten;
      pin_set(VEC[i].lvl);
      wr(A_CNT, 0);
      wr(A_CTRL, {9'd0, VEC[i].ctrl});
      for (int p = 0; p < int'(VEC[i].npulse); p++) begin
        pin_set(~VEC[i].lvl);
        pin_set(VEC[i].lvl);
      end
      for (int t = 0; t < int'(VEC[i].ntick); t++) tick();
      repeat (2) @(negedge clk);
      rd(A_CNT, v);
      chk($sformatf("R3/R4/R5/R6 vector %0d", i), v, VEC[i].exp);
    end
    tmr_en = 1'b1;

    // R7 selected edge sets the flag, opposite edge does not
    wr(A_CTRL, 0); pin_set(0); wr(A_STAT, 3);
    wr(A_CTRL, 16'h60);
    pin_set(1); rd(A_STAT, v); chk("R7 rising ignored pol0", v, 0);
    pin_set(0); rd(A_STAT, v); chk("R7 falling sets pol0", v, 1);
    wr(A_STAT, 3); rd(A_STAT, v); chk("R9 clear", v, 0);
    wr(A_CTRL, 16'h70);
    pin_set(1); rd(A_STAT, v); chk("R7 rising sets pol1", v, 1);

    // R10 interrupt gating
    chk("R10 irq masked", irq, 0);
    wr(A_CTRL, 16'h71); chk("R10 irq edge enabled", irq, 1);
    wr(A_STAT, 1);      chk("R10 irq after clear", irq, 0);

    // R8 overflow on wrap
    wr(A_CTRL, 0); pin_set(0); wr(A_CNT, 16'hFFFE); wr(A_STAT, 3);
    wr(A_CTRL, 16'h52);
    pin_set(1); pin_set(0); pin_set(1); pin_set(0);
    rd(A_CNT, v);  chk("R8 counter wrapped", v, 0);
    rd(A_STAT, v); chk("R8 status", v, 3);
    chk("R10 irq on overflow", irq, 1);

    // R9 set wins over same-cycle clear
    wr(A_CTRL, 0); pin_set(0); wr(A_STAT, 3); wr(A_CNT, 16'hFFFF);
    wr(A_CTRL, 16'h50);
    acc_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(A_STAT, 3);
    rd(A_STAT, v); chk("R9 set beats clear", v, 3);
    rd(A_CNT, v);  chk("R8 wrap count", v, 0);
    wr(A_STAT, 3); rd(A_STAT, v); chk("R9 clear both", v, 0);

    // R12 counter access and write priority
    wr(A_CTRL, 0); pin_set(0);
    wr(A_CNT, 16'h1234); rd(A_CNT, v); chk("R12 readback", v, 16'h1234);
    wr(A_CTRL, 16'h50); wr(A_CNT, 16'h0010);
    acc_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(A_CNT, 16'h0100);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R12 write beats increment", v, 16'h0100);

    // R11 exact timing of derived pulse
    wr(A_CTRL, 0); pin_set(0);
    wr(A_CTRL, 16'h54);
    presc_tick = 1'b1;
    acc_pin = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R11 before increment", tmr_clk_en, 0);
    @(negedge clk); #1;
    chk("R11 step pulse", tmr_clk_en, 1);
    @(negedge clk); #1;
    chk("R11 step pulse ends", tmr_clk_en, 0);
    wr(A_CTRL, 16'h50); #1; chk("R11 select prescaler", tmr_clk_en, 1);
    wr(A_CTRL, 16'h54); #1; chk("R11 select step", tmr_clk_en, 0);
    wr(A_CTRL, 16'h0C); #1; chk("R11 disabled forces prescaler", tmr_clk_en, 1);
    presc_tick = 1'b0;  #1; chk("R11 prescaler low", tmr_clk_en, 0);
    @(negedge clk);

    // R11 pulse counts per select
    wr(A_CTRL, 0); pin_set(0); wr(A_CNT, 16'h00FE); wr(A_CTRL, 16'h58);
    mon_cnt = 0; mon_on = 1'b1;
    for (int p = 0; p < 3; p++) begin pin_set(1); pin_set(0); end
    mon_on = 1'b0;
    chk("R11 low byte rollover pulses", mon_cnt, 1);

    wr(A_CTRL, 0); wr(A_CNT, 16'hFFFE); wr(A_CTRL, 16'h5C);
    mon_cnt = 0; mon_on = 1'b1;
    for (int p = 0; p < 3; p++) begin pin_set(1); pin_set(0); end
    mon_on = 1'b0;
    chk("R11 wrap pulses", mon_cnt, 1);

    wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_CTRL, 16'h54);
    mon_cnt = 0; mon_on = 1'b1;
    for (int p = 0; p < 3; p++) begin pin_set(1); pin_set(0); end
    mon_on = 1'b0;
    chk("R11 step pulses", mon_cnt, 3);

    done = 1'b1;
    summary();
  end
endmodule